// File: doc/BRIEF.md
# Serial Controller Host Interface and Configuration Sequencer

This block is the processor-side front end of a programmable serial controller. It turns four host signals into one of four bus accesses: chip select (active low), a control/data select, and read and write strobes (both active low). The four accesses are a status read, a control-word write, a received-data read and a transmit-data write. It also drives the enable for the tri-state data bus. Data writes go to the transmitter as a one-cycle load pulse. Data reads give a one-cycle pulse to the receiver, so the receiver can clear its ready flag.

A control write has no fixed register address. Its meaning depends on where it falls in the sequence since the last reset. The first control write is the mode word. In synchronous mode, one or two sync-character writes follow it. After that, every control write is a command. A command that sets the internal-reset bit sends the sequencer back to waiting for a mode word. The decoded mode fields and the sync characters are held in registers and exported to the transmitter and receiver.

All host inputs are sampled on the system clock. A write or read takes effect once per strobe, on the first clock edge where the strobe is seen low.

Top module: `sercfg_bus_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cfg_done`, `cmd_load`, `tx_load`, `rx_read` and `dbus_oe` are 0, and all mode fields and sync characters are 0.
- R2: `dbus_oe` is 1 only when `cs_n`=0, `rd_n`=0 and `wr_n`=1. While it is 1, `dbus_out` equals `status_in` when `cd_sel`=1 and `rxdata_in` when `cd_sel`=0.
- R3: A data write (`cs_n`=0, `cd_sel`=0, `wr_n` low, `rd_n` high) pulses `tx_load` high for exactly one cycle, in the cycle after the first edge with `wr_n` low. `tx_data` then holds the bus value. A strobe held low for several cycles gives only one pulse.
- R4: A data read (`cs_n`=0, `cd_sel`=0, `rd_n` low, `wr_n` high) pulses `rx_read` for one cycle, in the cycle after the first edge with `rd_n` low.
- R5: The first control write after reset is the mode word. Bits 1:0 go to `baud_sel`, bits 3:2 to `char_len`, bit 4 to `par_en`, bit 5 to `par_even`, and bits 7:6 to `stop_sync`.
- R6: A mode word with bits 1:0 not equal to 00 (asynchronous) raises `cfg_done` in the next cycle. Every later control write is a command: `cmd_load` pulses for one cycle and `cmd_word` holds the value.
- R7: A mode word with bits 1:0 = 00 and bit 7 = 1 (single sync) makes the next control write the first sync character (`sync_char1`). `cfg_done` rises after that write.
- R8: A mode word with bits 1:0 = 00 and bit 7 = 0 (two sync) takes two more control writes, stored in order in `sync_char1` and `sync_char2`. `cfg_done` rises only after the second. Data writes in between do not advance the sequence.
- R9: A command with bit 6 = 1 is an internal reset. It lowers `cfg_done`, gives no `cmd_load` pulse, and makes the next control write a mode word.
- R10: A write while `cs_n`=1, or while `rd_n` is also low, is ignored. It gives no load pulse and causes no change in sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| cd_sel | input | 1 | 1 = control/status, 0 = data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dbus_in | input | 8 | Write data from host |
| dbus_out | output | 8 | Read data to host |
| dbus_oe | output | 1 | Tri-state enable for the host data bus |
| status_in | input | 8 | Status byte from the controller |
| rxdata_in | input | 8 | Received character from the receiver |
| tx_data | output | 8 | Character for the transmitter |
| tx_load | output | 1 | One-cycle transmit load pulse |
| rx_read | output | 1 | One-cycle received-data taken pulse |
| cmd_word | output | 8 | Last command word |
| cmd_load | output | 1 | One-cycle command pulse |
| baud_sel | output | 2 | Mode: baud factor, 00 = synchronous |
| char_len | output | 2 | Mode: character length code |
| par_en | output | 1 | Mode: parity enable |
| par_even | output | 1 | Mode: even parity |
| stop_sync | output | 2 | Mode: stop bits or sync options |
| sync_char1 | output | 8 | First sync character |
| sync_char2 | output | 8 | Second sync character |
| cfg_done | output | 1 | Mode setting complete, commands accepted |

## Verification
If the sequencer is in the wrong state, the next control write lands in the wrong place. A command shows up as a change to a sync character or a mode field. Or a sync character raises `cmd_load`, or `cfg_done` rises one write early or late. All of these are visible one cycle after the offending strobe edge. A fault in strobe edge detection shows up as repeated or missing load pulses during a held strobe. A decode fault shows up at once as a wrong `dbus_oe` level or a wrong source on `dbus_out`.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  typedef enum logic [1:0] {
    SQ_MODE  = 2'd0,
    SQ_SYNC1 = 2'd1,
    SQ_SYNC2 = 2'd2,
    SQ_CMD   = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic [1:0] stop_sync;
    logic       par_even;
    logic       par_en;
    logic [1:0] char_len;
    logic [1:0] baud_sel;
  } mode_word_t;

  localparam int unsigned IRST_BIT     = 6;
  localparam int unsigned SYNC_ONE_BIT = 7;
endpackage

// File: rtl/sercfg_decode.sv
module sercfg_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic cd_sel,
  input  logic rd_n,
  input  logic wr_n,
  output logic ctrl_wr_ev,
  output logic data_wr_ev,
  output logic data_rd_ev,
  output logic bus_oe
);
  logic wr_prev_q, rd_prev_q;
  logic wr_ok, rd_ok;

  assign wr_ok  = !cs_n && !wr_n && rd_n;
  assign rd_ok  = !cs_n && !rd_n && wr_n;
  assign bus_oe = rd_ok;

  always_comb begin
    ctrl_wr_ev = wr_ok && wr_prev_q && cd_sel;
    data_wr_ev = wr_ok && wr_prev_q && !cd_sel;
    data_rd_ev = rd_ok && rd_prev_q && !cd_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b1;
      rd_prev_q <= 1'b1;
    end else begin
      wr_prev_q <= wr_n;
      rd_prev_q <= rd_n;
    end
  end
endmodule

// File: rtl/sercfg_seq.sv
module sercfg_seq
  import sercfg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr_ev,
  input  logic [DW-1:0] wdata,
  output logic          ld_mode,
  output logic          ld_sync1,
  output logic          ld_sync2,
  output logic          ld_cmd,
  output logic          cfg_done
);
  seq_state_t state_q, state_d;
  logic       is_sync, one_sync, irst;

  assign is_sync  = (wdata[1:0] == 2'b00);
  assign one_sync = wdata[SYNC_ONE_BIT];
  assign irst     = wdata[IRST_BIT];

  always_comb begin
    state_d  = state_q;
    ld_mode  = 1'b0;
    ld_sync1 = 1'b0;
    ld_sync2 = 1'b0;
    ld_cmd   = 1'b0;
    if (ctrl_wr_ev) begin
      unique case (state_q)
        SQ_MODE: begin
          ld_mode = 1'b1;
          state_d = is_sync ? SQ_SYNC1 : SQ_CMD;
        end
        SQ_SYNC1: begin
          ld_sync1 = 1'b1;
          state_d  = one_sync_q ? SQ_CMD : SQ_SYNC2;
        end
        SQ_SYNC2: begin
          ld_sync2 = 1'b1;
          state_d  = SQ_CMD;
        end
        SQ_CMD: begin
          if (irst) state_d = SQ_MODE;
          else      ld_cmd  = 1'b1;
        end
        default: state_d = SQ_MODE;
      endcase
    end
  end

  logic one_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_MODE;
      one_sync_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ld_mode) one_sync_q <= one_sync;
    end
  end

  assign cfg_done = (state_q == SQ_CMD);
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wdata,
  input  logic          ld_mode,
  input  logic          ld_sync1,
  input  logic          ld_sync2,
  input  logic          ld_cmd,
  input  logic          ld_tx,
  input  logic          rd_ev,
  output mode_word_t    mode,
  output logic [DW-1:0] sync1,
  output logic [DW-1:0] sync2,
  output logic [DW-1:0] cmd,
  output logic [DW-1:0] txd,
  output logic          cmd_pulse,
  output logic          tx_pulse,
  output logic          rd_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;
      sync1 <= '0;
      sync2 <= '0;
      cmd   <= '0;
      txd   <= '0;
    end else begin
      if (ld_mode)  mode  <= mode_word_t'(wdata[7:0]);
      if (ld_sync1) sync1 <= wdata;
      if (ld_sync2) sync2 <= wdata;
      if (ld_cmd)   cmd   <= wdata;
      if (ld_tx)    txd   <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_pulse <= 1'b0;
      tx_pulse  <= 1'b0;
      rd_pulse  <= 1'b0;
    end else begin
      cmd_pulse <= ld_cmd;
      tx_pulse  <= ld_tx;
      rd_pulse  <= rd_ev;
    end
  end
endmodule

// File: rtl/sercfg_bus_seq.sv
module sercfg_bus_seq
  import sercfg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cd_sel,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] dbus_in,
  output logic [DW-1:0] dbus_out,
  output logic          dbus_oe,
  input  logic [DW-1:0] status_in,
  input  logic [DW-1:0] rxdata_in,
  output logic [DW-1:0] tx_data,
  output logic          tx_load,
  output logic          rx_read,
  output logic [DW-1:0] cmd_word,
  output logic          cmd_load,
  output logic [1:0]    baud_sel,
  output logic [1:0]    char_len,
  output logic          par_en,
  output logic          par_even,
  output logic [1:0]    stop_sync,
  output logic [DW-1:0] sync_char1,
  output logic [DW-1:0] sync_char2,
  output logic          cfg_done
);
  logic       ctrl_wr_ev, data_wr_ev, data_rd_ev;
  logic       ld_mode, ld_sync1, ld_sync2, ld_cmd;
  mode_word_t mode;

  sercfg_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cd_sel(cd_sel),
    .rd_n(rd_n), .wr_n(wr_n), .ctrl_wr_ev(ctrl_wr_ev),
    .data_wr_ev(data_wr_ev), .data_rd_ev(data_rd_ev), .bus_oe(dbus_oe)
  );

  sercfg_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_ev(ctrl_wr_ev), .wdata(dbus_in),
    .ld_mode(ld_mode), .ld_sync1(ld_sync1), .ld_sync2(ld_sync2),
    .ld_cmd(ld_cmd), .cfg_done(cfg_done)
  );

  sercfg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(dbus_in), .ld_mode(ld_mode),
    .ld_sync1(ld_sync1), .ld_sync2(ld_sync2), .ld_cmd(ld_cmd),
    .ld_tx(data_wr_ev), .rd_ev(data_rd_ev), .mode(mode),
    .sync1(sync_char1), .sync2(sync_char2), .cmd(cmd_word), .txd(tx_data),
    .cmd_pulse(cmd_load), .tx_pulse(tx_load), .rd_pulse(rx_read)
  );

  assign dbus_out  = cd_sel ? status_in : rxdata_in;
  assign baud_sel  = mode.baud_sel;
  assign char_len  = mode.char_len;
  assign par_en    = mode.par_en;
  assign par_even  = mode.par_even;
  assign stop_sync = mode.stop_sync;
endmodule

// File: rtl/sercfg_bus_seq_chk.sv
module sercfg_bus_seq_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          cd_sel,
  input logic          rd_n,
  input logic          wr_n,
  input logic          dbus_oe,
  input logic [DW-1:0] dbus_out,
  input logic [DW-1:0] status_in,
  input logic [DW-1:0] rxdata_in,
  input logic          tx_load,
  input logic          cmd_load,
  input logic          rx_read,
  input logic          cfg_done
);
  // R2
  oe_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_oe |-> (!cs_n && !rd_n && wr_n &&
                 dbus_out == (cd_sel ? status_in : rxdata_in)));
  // R3
  tx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);
  // R3
  tx_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> $past(!cs_n && !cd_sel && !wr_n && rd_n));
  // R4
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_read |=> !rx_read);
  // R6
  cmd_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |-> cfg_done);
  // R9
  irst_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_done) |-> !cmd_load);
  // R10
  one_load_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_load, tx_load}));
endmodule

bind sercfg_bus_seq sercfg_bus_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cd_sel(cd_sel), .rd_n(rd_n),
  .wr_n(wr_n), .dbus_oe(dbus_oe), .dbus_out(dbus_out),
  .status_in(status_in), .rxdata_in(rxdata_in), .tx_load(tx_load),
  .cmd_load(cmd_load), .rx_read(rx_read), .cfg_done(cfg_done)
);

// File: tb/sim_sercfg_bus_seq.sv
module sim_sercfg_bus_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, cd_sel, rd_n, wr_n;
  logic [7:0] dbus_in, status_in, rxdata_in;
  logic [7:0] dbus_out, tx_data, cmd_word, sync_char1, sync_char2;
  logic       dbus_oe, tx_load, rx_read, cmd_load, par_en, par_even, cfg_done;
  logic [1:0] baud_sel, char_len, stop_sync;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sercfg_bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cd_sel(cd_sel), .rd_n(rd_n),
    .wr_n(wr_n), .dbus_in(dbus_in), .dbus_out(dbus_out), .dbus_oe(dbus_oe),
    .status_in(status_in), .rxdata_in(rxdata_in), .tx_data(tx_data),
    .tx_load(tx_load), .rx_read(rx_read), .cmd_word(cmd_word),
    .cmd_load(cmd_load), .baud_sel(baud_sel), .char_len(char_len),
    .par_en(par_en), .par_even(par_even), .stop_sync(stop_sync),
    .sync_char1(sync_char1), .sync_char2(sync_char2), .cfg_done(cfg_done)
  );

  // {control?, data, expected cfg_done, expected cmd_load, expected tx_load, req}
  typedef struct packed {
    logic       ctl;
    logic [7:0] data;
    logic       done;
    logic       cmd;
    logic       tx;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h4E, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 async mode word
    '{1'b1, 8'h15, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 command
    '{1'b0, 8'hA5, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 data write
    '{1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 internal reset
    '{1'b1, 8'h9C, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 single sync mode
    '{1'b1, 8'h16, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 sync char
    '{1'b1, 8'h37, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 command
    '{1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
    '{1'b1, 8'h1C, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 two sync mode
    '{1'b0, 8'h3C, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 data write does not advance
    '{1'b1, 8'hAA, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 first sync
    '{1'b1, 8'h55, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 second sync
    '{1'b1, 8'h05, 1'b1, 1'b1, 1'b0, 4'd6}   // R6 command
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; cd_sel = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  // drive one write at a negedge; after return, one posedge has passed
  task automatic wr_start(input logic ctl, input logic [7:0] d);
    cs_n = 1'b0; cd_sel = ctl; wr_n = 1'b0; rd_n = 1'b1; dbus_in = d;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; dbus_in = '0; status_in = 8'hC3; rxdata_in = 8'h69;
    idle();
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 cfg_done", cfg_done, 0);
    chk("R1 pulses", {cmd_load, tx_load, rx_read, dbus_oe}, 0);
    chk("R1 mode", {baud_sel, char_len, par_en, par_even, stop_sync}, 0);
    chk("R1 sync", {sync_char1, sync_char2}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {cfg_done, cmd_load, tx_load, rx_read}, 0);

    for (int i = 0; i < NVEC; i++) begin
      wr_start(VECS[i].ctl, VECS[i].data);
      idle();
      if ({cfg_done, cmd_load, tx_load} !== {VECS[i].done, VECS[i].cmd, VECS[i].tx}) begin
        vec_cnt++; err_cnt++;
        $display("FAIL R%0d vec %0d actual=%b expected=%b", VECS[i].req, i,
                 {cfg_done, cmd_load, tx_load}, {VECS[i].done, VECS[i].cmd, VECS[i].tx});
      end else vec_cnt++;
      if (VECS[i].cmd) chk("R6 cmd_word", cmd_word, VECS[i].data);
      if (VECS[i].tx)  chk("R3 tx_data", tx_data, VECS[i].data);
      @(negedge clk);
    end
    // R8 two sync characters in order, R5 fields of 0x1C
    chk("R8 sync1", sync_char1, 8'hAA);
    chk("R8 sync2", sync_char2, 8'h55);
    chk("R5 fields", {stop_sync, par_even, par_en, char_len, baud_sel},
        {2'b00, 1'b0, 1'b1, 2'b11, 2'b00});

    // R5 async mode fields after internal reset: 0xE6
    wr_start(1'b1, 8'h40); idle(); @(negedge clk);
    wr_start(1'b1, 8'hE6); idle();
    chk("R5 fields async", {stop_sync, par_even, par_en, char_len, baud_sel},
        {2'b11, 1'b1, 1'b0, 2'b01, 2'b10});
    chk("R6 done", cfg_done, 1);
    @(negedge clk);

    // R3 held strobe gives one pulse
    wr_start(1'b0, 8'h81);
    chk("R3 first pulse", tx_load, 1);
    @(negedge clk);
    chk("R3 no repeat", tx_load, 0);
    @(negedge clk);
    chk("R3 no repeat2", tx_load, 0);
    idle(); @(negedge clk);

    // R10 write with cs_n high
    cs_n = 1'b1; cd_sel = 1'b1; wr_n = 1'b0; dbus_in = 8'h40;
    @(negedge clk);
    chk("R10 cs high", {cmd_load, tx_load, cfg_done}, 3'b001);
    idle(); @(negedge clk);
    // R10 write with rd also low
    cs_n = 1'b0; cd_sel = 1'b1; wr_n = 1'b0; rd_n = 1'b0; dbus_in = 8'h40;
    #1 chk("R10 oe off", dbus_oe, 0);
    @(negedge clk);
    chk("R10 rd+wr", {cmd_load, tx_load, cfg_done}, 3'b001);
    idle(); @(negedge clk);
    wr_start(1'b1, 8'h11); idle();
    chk("R10 state kept", {cmd_load, cmd_word}, {1'b1, 8'h11});
    @(negedge clk);

    // R2 status read and data read, R4 rx_read pulse
    cs_n = 1'b0; cd_sel = 1'b1; rd_n = 1'b0;
    #1 chk("R2 status", {dbus_oe, dbus_out}, {1'b1, 8'hC3});
    @(negedge clk);
    chk("R4 no pulse on status", rx_read, 0);
    idle(); #1 chk("R2 oe off", dbus_oe, 0);
    @(negedge clk);
    cs_n = 1'b0; cd_sel = 1'b0; rd_n = 1'b0;
    #1 chk("R2 rxdata", {dbus_oe, dbus_out}, {1'b1, 8'h69});
    @(negedge clk);
    chk("R4 pulse", rx_read, 1);
    @(negedge clk);
    chk("R4 single", rx_read, 0);
    idle(); @(negedge clk);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      vec_cnt++; err_cnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end
endmodule